// File: doc/BRIEF.md
# GPIO Port Register File

A 32-bit memory-mapped register file for a general purpose I/O port. It keeps the output level vector, the direction vector and one configuration word per pin, and it returns the resolved input vector that an external pin resolver supplies. Both the output vector and the direction vector can be written in three ways: as a whole word, through a set alias that ORs the written ones in, and through a clear alias that clears each bit written as one.

Direction is visible in two places: in the direction vector and in bit 0 of every pin's configuration word. Any write path that changes one copy changes the other in the same cycle. The block stores direction only once and builds bit 0 of each configuration word from it, so the two copies never differ. The output vector, the direction vector and all configuration words are driven out continuously to the pin resolver.

The bus is a single-cycle word bus with no wait states. A request is sampled on a rising edge. A write takes effect on that edge. Read data and the bad-access flag are registered and become valid after that same edge.

Top module: `gpio_regs`

## Requirements
- R1: While reset is held and after it is released, the output vector and the direction vector are 0, every configuration word reads 0x00000002, read data is 0 and the bad-access flag is low.
- R2: A write to 0x504 replaces the output vector. A read of 0x504, 0x508 or 0x50C returns the output vector.
- R3: A write to 0x508 sets the output bits written as one. A write to 0x50C clears the output bits written as one. Bits written as zero keep their value.
- R4: The direction vector has the same three forms: replace at 0x514, set at 0x518, clear at 0x51C. A read of any of these three addresses returns the direction vector.
- R5: After any write to 0x514, 0x518 or 0x51C, bit 0 of the configuration word of pin i equals direction bit i. Bits 31:1 of every configuration word are not changed.
- R6: A write to the configuration word of pin i at 0x700 + 4*i stores all 32 bits and sets direction bit i to bit 0 of the written value. The other direction bits are not changed.
- R7: A read of 0x700 + 4*i returns the configuration word of pin i, and the cfg_words port carries word i in bits 32*i+31 down to 32*i.
- R8: A read of 0x510 returns pin_in as sampled at the request edge. A write to 0x510 changes no state and does not raise the bad-access flag.
- R9: An access to an unmapped address returns read data 0 and raises the bad-access flag for one cycle. A write to such an address changes no state. Unmapped includes any address with bits 1:0 not zero and any address past the last configuration word (0x77C).
- R10: A write is visible on out_level, dir_mask and cfg_words right after the request edge. Read data is valid after the request edge and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Request valid |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Bad-access pulse, one cycle after the request |
| pin_in | input | 32 | Resolved input level vector |
| out_level | output | 32 | Output level vector |
| dir_mask | output | 32 | Direction vector, 1 = output |
| cfg_words | output | 1024 | All configuration words, pin i at bits 32*i+31:32*i |

## Verification
Every result of this block is due one edge after the request. Write effects reach out_level, dir_mask and cfg_words on the edge that samples the write, and read data and the bad-access flag are registered on that same edge. The bench drives each request on a falling edge and drops it on the next falling edge. It checks the outputs at that second falling edge, which lies half a cycle after the edge that made them, before the next edge can change them. One directed case checks that read data still holds one cycle later, after an unrelated write.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int DW = 32;

  localparam int A_OUT      = 'h504;
  localparam int A_OUTSET   = 'h508;
  localparam int A_OUTCLR   = 'h50C;
  localparam int A_IN       = 'h510;
  localparam int A_DIR      = 'h514;
  localparam int A_DIRSET   = 'h518;
  localparam int A_DIRCLR   = 'h51C;
  localparam int A_CFG_BASE = 'h700;

  localparam logic [DW-1:0] CFG_RESET = 32'h0000_0002;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_OUT, SEL_OUTSET, SEL_OUTCLR, SEL_IN,
    SEL_DIR, SEL_DIRSET, SEL_DIRCLR, SEL_CFG
  } reg_sel_e;

  typedef enum logic [1:0] {
    FORM_NONE, FORM_PLAIN, FORM_SET, FORM_CLR
  } wr_form_e;

  function automatic wr_form_e form_of(input reg_sel_e s);
    case (s)
      SEL_OUT, SEL_DIR:       return FORM_PLAIN;
      SEL_OUTSET, SEL_DIRSET: return FORM_SET;
      SEL_OUTCLR, SEL_DIRCLR: return FORM_CLR;
      default:                return FORM_NONE;
    endcase
  endfunction

  function automatic logic in_out_group(input reg_sel_e s);
    return (s == SEL_OUT) || (s == SEL_OUTSET) || (s == SEL_OUTCLR);
  endfunction

  function automatic logic in_dir_group(input reg_sel_e s);
    return (s == SEL_DIR) || (s == SEL_DIRSET) || (s == SEL_DIRCLR);
  endfunction
endpackage

// File: rtl/gpr_decode.sv
module gpr_decode
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_PINS = 32,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] CFG_LO = ADDR_W'(A_CFG_BASE);
  localparam logic [ADDR_W-1:0] CFG_HI = ADDR_W'(A_CFG_BASE + 4 * (N_PINS - 1));

  always_comb begin
    sel = SEL_NONE;
    idx = '0;
    if (addr[1:0] == 2'b00) begin
      case (addr)
        ADDR_W'(A_OUT):    sel = SEL_OUT;
        ADDR_W'(A_OUTSET): sel = SEL_OUTSET;
        ADDR_W'(A_OUTCLR): sel = SEL_OUTCLR;
        ADDR_W'(A_IN):     sel = SEL_IN;
        ADDR_W'(A_DIR):    sel = SEL_DIR;
        ADDR_W'(A_DIRSET): sel = SEL_DIRSET;
        ADDR_W'(A_DIRCLR): sel = SEL_DIRCLR;
        default:           sel = SEL_NONE;
      endcase
      if (addr >= CFG_LO && addr <= CFG_HI) begin
        sel = SEL_CFG;
        idx = IDX_W'((addr - CFG_LO) >> 2);
      end
    end
  end
endmodule

// File: rtl/gpr_maskreg.sv
module gpr_maskreg
  import gpr_pkg::*;
#(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  wr_form_e         form,
  input  logic [W-1:0]     wdata,
  input  logic             bit_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);
  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      case (form)
        FORM_PLAIN: nxt = wdata;
        FORM_SET:   nxt = q | wdata;
        FORM_CLR:   nxt = q & ~wdata;
        default:    nxt = q;
      endcase
    end
    if (bit_en) nxt[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/gpr_cfgarray.sv
module gpr_cfgarray
  import gpr_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wdata,
  input  logic [N_PINS-1:0]    dir_in,
  output logic [N_PINS*DW-1:0] cfg_flat
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [DW-1:1] upper;
    logic          hit;
    assign hit = wr_en && (wr_idx == IDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   upper <= CFG_RESET[DW-1:1];
      else if (hit) upper <= wdata[DW-1:1];
    end

    // bit 0 is the single stored direction copy
    assign cfg_flat[p*DW +: DW] = {upper, dir_in[p]};
  end
endmodule

// File: rtl/gpr_rdmux.sv
module gpr_rdmux
  import gpr_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int IDX_W  = $clog2(N_PINS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  reg_sel_e             sel,
  input  logic [IDX_W-1:0]     idx,
  input  logic [N_PINS-1:0]    out_q,
  input  logic [N_PINS-1:0]    dir_q,
  input  logic [N_PINS-1:0]    pin_in,
  input  logic [N_PINS*DW-1:0] cfg_flat,
  output logic [DW-1:0]        rdata
);
  logic [DW-1:0] pick;

  always_comb begin
    case (sel)
      SEL_OUT, SEL_OUTSET, SEL_OUTCLR: pick = DW'(out_q);
      SEL_DIR, SEL_DIRSET, SEL_DIRCLR: pick = DW'(dir_q);
      SEL_IN:                          pick = DW'(pin_in);
      SEL_CFG:                         pick = cfg_flat[idx*DW +: DW];
      default:                         pick = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= pick;
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_PINS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 bus_err,
  input  logic [N_PINS-1:0]    pin_in,
  output logic [N_PINS-1:0]    out_level,
  output logic [N_PINS-1:0]    dir_mask,
  output logic [N_PINS*DW-1:0] cfg_words
);
  localparam int IDX_W = $clog2(N_PINS);

  reg_sel_e         sel;
  logic [IDX_W-1:0] cfg_idx;
  wr_form_e         form;

  // named events for the checker
  logic rd_req, wr_req, wr_out, wr_dir, wr_cfg, bad_req;

  gpr_decode #(.ADDR_W(ADDR_W), .N_PINS(N_PINS), .IDX_W(IDX_W)) u_decode (
    .addr (bus_addr),
    .sel  (sel),
    .idx  (cfg_idx)
  );

  assign form    = form_of(sel);
  assign rd_req  = bus_en && !bus_we;
  assign wr_req  = bus_en && bus_we;
  assign wr_out  = wr_req && in_out_group(sel);
  assign wr_dir  = wr_req && in_dir_group(sel);
  assign wr_cfg  = wr_req && (sel == SEL_CFG);
  assign bad_req = bus_en && (sel == SEL_NONE);

  gpr_maskreg #(.W(N_PINS), .IDX_W(IDX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_out),
    .form    (form),
    .wdata   (bus_wdata[N_PINS-1:0]),
    .bit_en  (1'b0),
    .bit_idx ('0),
    .bit_val (1'b0),
    .q       (out_level)
  );

  gpr_maskreg #(.W(N_PINS), .IDX_W(IDX_W)) u_dir (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_dir),
    .form    (form),
    .wdata   (bus_wdata[N_PINS-1:0]),
    .bit_en  (wr_cfg),
    .bit_idx (cfg_idx),
    .bit_val (bus_wdata[0]),
    .q       (dir_mask)
  );

  gpr_cfgarray #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_cfg),
    .wr_idx   (cfg_idx),
    .wdata    (bus_wdata),
    .dir_in   (dir_mask),
    .cfg_flat (cfg_words)
  );

  gpr_rdmux #(.N_PINS(N_PINS), .IDX_W(IDX_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_req),
    .sel      (sel),
    .idx      (cfg_idx),
    .out_q    (out_level),
    .dir_q    (dir_mask),
    .pin_in   (pin_in),
    .cfg_flat (cfg_words),
    .rdata    (bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_err <= 1'b0;
    else        bus_err <= bad_req;
  end
endmodule

// File: rtl/gpio_regs_checker.sv
module gpio_regs_checker
  import gpr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int N_PINS = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DW-1:0]        bus_wdata,
  input logic                 bus_err,
  input logic [N_PINS-1:0]    out_level,
  input logic [N_PINS-1:0]    dir_mask
);
  localparam int IDX_W = $clog2(N_PINS);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(A_CFG_BASE);
  localparam logic [ADDR_W-1:0] HI = ADDR_W'(A_CFG_BASE + 4 * (N_PINS - 1));

  logic             wr;
  logic             cfg_hit;
  logic [IDX_W-1:0] pin;
  assign wr      = bus_en && bus_we;
  assign cfg_hit = wr && bus_addr[1:0] == 2'b00 && bus_addr >= LO && bus_addr <= HI;
  assign pin     = IDX_W'((bus_addr - LO) >> 2);

  assert_out_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(A_OUT)) |=> out_level == $past(bus_wdata[N_PINS-1:0]));

  assert_out_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(A_OUTSET)) |=>
      out_level == ($past(out_level) | $past(bus_wdata[N_PINS-1:0])));

  assert_out_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(A_OUTCLR)) |=>
      out_level == ($past(out_level) & ~$past(bus_wdata[N_PINS-1:0])));

  assert_dir_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(A_DIRSET)) |=>
      dir_mask == ($past(dir_mask) | $past(bus_wdata[N_PINS-1:0])));

  assert_cfg_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> dir_mask[$past(pin)] == $past(bus_wdata[0]));

  assert_in_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'(A_IN)) |=>
      ($stable(out_level) && $stable(dir_mask) && !bus_err));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past(bus_en));
endmodule

bind gpio_regs gpio_regs_checker #(.ADDR_W(ADDR_W), .N_PINS(N_PINS)) u_chk (.*);

// File: tb/gpio_regs_bench.sv
module gpio_regs_bench;
  localparam int AW = 12;
  localparam int NP = 32;

  typedef struct packed {
    logic        is_wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp_out;
    logic [31:0] exp_dir;
    logic [31:0] exp_rd;
    logic        exp_err;
  } vec_t;

  // pin_in is held at 32'hA5A50F0F throughout
  localparam vec_t VEC [14] = '{
    '{1'b1, 12'h504, 32'h1234_5678, 32'h1234_5678, 32'h0,         32'h0,         1'b0}, // R2
    '{1'b1, 12'h508, 32'h0000_0081, 32'h1234_56F9, 32'h0,         32'h0,         1'b0}, // R3
    '{1'b1, 12'h50C, 32'h1200_0001, 32'h0034_56F8, 32'h0,         32'h0,         1'b0}, // R3
    '{1'b0, 12'h508, 32'h0,         32'h0034_56F8, 32'h0,         32'h0034_56F8, 1'b0}, // R2
    '{1'b1, 12'h514, 32'h0000_00FF, 32'h0034_56F8, 32'h0000_00FF, 32'h0,         1'b0}, // R4
    '{1'b1, 12'h518, 32'h8000_0100, 32'h0034_56F8, 32'h8000_01FF, 32'h0,         1'b0}, // R4
    '{1'b1, 12'h51C, 32'h0000_000F, 32'h0034_56F8, 32'h8000_01F0, 32'h0,         1'b0}, // R4
    '{1'b0, 12'h51C, 32'h0,         32'h0034_56F8, 32'h8000_01F0, 32'h8000_01F0, 1'b0}, // R4
    '{1'b0, 12'h510, 32'h0,         32'h0034_56F8, 32'h8000_01F0, 32'hA5A5_0F0F, 1'b0}, // R8
    '{1'b1, 12'h510, 32'hFFFF_FFFF, 32'h0034_56F8, 32'h8000_01F0, 32'h0,         1'b0}, // R8
    '{1'b0, 12'h600, 32'h0,         32'h0034_56F8, 32'h8000_01F0, 32'h0,         1'b1}, // R9
    '{1'b1, 12'h780, 32'h0000_0001, 32'h0034_56F8, 32'h8000_01F0, 32'h0,         1'b1}, // R9
    '{1'b0, 12'h506, 32'h0,         32'h0034_56F8, 32'h8000_01F0, 32'h0,         1'b1}, // R9
    '{1'b0, 12'h50C, 32'h0,         32'h0034_56F8, 32'h8000_01F0, 32'h0034_56F8, 1'b0}  // R2
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_en = 1'b0;
  logic           bus_we = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic           bus_err;
  logic [NP-1:0]  pin_in = 32'hA5A5_0F0F;
  logic [NP-1:0]  out_level;
  logic [NP-1:0]  dir_mask;
  logic [NP*32-1:0] cfg_words;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_regs #(.ADDR_W(AW), .N_PINS(NP)) u_gpio_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pin_in(pin_in), .out_level(out_level),
    .dir_mask(dir_mask), .cfg_words(cfg_words)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic we, input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    bus_en = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [31:0] cfg_of(input int p);
    return cfg_words[p*32 +: 32];
  endfunction

  task automatic check_reset_state();
    check("R1 out", out_level, 32'h0);
    check("R1 dir", dir_mask, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 err", {31'h0, bus_err}, 32'h0);
    for (int p = 0; p < NP; p++) check($sformatf("R1 cfg%0d", p), cfg_of(p), 32'h2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R2 R3 R4 R8 R9, effects due after the request edge (R10)
    for (int v = 0; v < 14; v++) begin
      bus_op(VEC[v].is_wr, VEC[v].addr, VEC[v].data);
      check($sformatf("R10 v%0d out", v), out_level, VEC[v].exp_out);
      check($sformatf("R10 v%0d dir", v), dir_mask, VEC[v].exp_dir);
      check($sformatf("R9 v%0d err", v), {31'h0, bus_err}, {31'h0, VEC[v].exp_err});
      if (!VEC[v].is_wr) check($sformatf("R2 v%0d rdata", v), bus_rdata, VEC[v].exp_rd);
    end

    // R5: bit 0 of each word follows direction 0x800001F0
    for (int p = 0; p < NP; p++)
      check($sformatf("R5 cfg%0d", p), cfg_of(p), (p == 31 || (p >= 4 && p <= 8)) ? 32'h3 : 32'h2);

    // R7: reads of configuration words
    bus_op(1'b0, 12'h704, 32'h0);
    check("R7 read pin1", bus_rdata, 32'h0000_0002);
    bus_op(1'b0, 12'h710, 32'h0);
    check("R7 read pin4", bus_rdata, 32'h0000_0003);

    // R6: configuration write drives direction bit
    bus_op(1'b1, 12'h708, 32'h0000_0305);
    check("R6 dir after pin2", dir_mask, 32'h8000_01F4);
    check("R7 port pin2", cfg_of(2), 32'h0000_0305);
    bus_op(1'b1, 12'h77C, 32'h0000_0700);
    check("R6 dir after pin31", dir_mask, 32'h0000_01F4);
    check("R7 port pin31", cfg_of(31), 32'h0000_0700);

    // R5: direction clear keeps upper config bits
    bus_op(1'b1, 12'h51C, 32'h0000_0004);
    check("R5 dir after clr", dir_mask, 32'h0000_01F0);
    bus_op(1'b0, 12'h708, 32'h0);
    check("R5 read pin2", bus_rdata, 32'h0000_0304);

    // R10: read data holds across a following write
    bus_op(1'b0, 12'h50C, 32'h0);
    check("R10 read out", bus_rdata, 32'h0034_56F8);
    bus_op(1'b1, 12'h504, 32'h0);
    check("R10 rdata hold", bus_rdata, 32'h0034_56F8);
    check("R2 out cleared", out_level, 32'h0);

    // R1: reset returns everything to its initial state
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule